// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver

This block is an asynchronous serial transmitter and receiver. Each direction has one holding buffer in front of its shift register. A byte can therefore wait to be sent while the previous one is still shifting out, and a received byte can wait to be read while the next one arrives. The character format is set by plain configuration pins:

- 7 or 8 data bits
- no parity, even parity or odd parity
- one or two stop bits

Bit timing comes from an oversampling tick, and one bit lasts 16 ticks. The tick is either an internal divider of the core clock or a rising edge of an external clock input.

Transmit data enters through a valid/ready stream. `tx_ready` is the empty flag of the transmit holding buffer. A byte is taken on a cycle where both `tx_valid` and `tx_ready` are high, and `tx_ready` then stays low until the byte moves into the shift register.

Received data leaves through a valid/ready stream. `rx_valid` is the full flag of the receive holding buffer. `rx_data` stays stable until a cycle where `rx_ready` is high, and that handshake empties the buffer.

The block has no back-pressure toward the serial line. A frame that completes while the receive buffer is still full is reported as an overrun. A status byte reports the buffer flags, the shift-complete flag and latched error flags, and a pulse input clears the error flags.

Top module: `sio_uart`

## Requirements
- R1: After reset with transmit disabled, `status` reads 8'h80. The status bits are: bit 0 transmit-buffer-empty, bit 1 receive-buffer-full, bit 2 shift-complete, bit 3 overrun, bit 4 parity error, bit 5 framing error, bit 6 error summary (the OR of bits 3 to 5), and bit 7 always 1.
- R2: `txd` idles at 1 and sends each character LSB first, in this order:
  - a 0 start bit;
  - 7 data bits (`char7`=1) or 8 data bits (`char7`=0);
  - a parity bit when `par_en`=1, chosen so that the count of ones in the data and parity is even (`par_odd`=0) or odd (`par_odd`=1);
  - one stop bit at 1 (`stop2`=0) or two (`stop2`=1).
- R3: One bit lasts 16 ticks. With `ext_sel`=0 a tick occurs every `baud_div`+1 clock cycles. With `ext_sel`=1 a tick occurs on each rising edge of `ext_clk`.
- R4: The receiver accepts every format of R2 and returns the data in `rx_data`. In 7-bit mode, bit 7 of `rx_data` is 0.
- R5: Shift-complete goes to 0 when a character starts shifting. It goes to 1 when the last stop bit begins, provided no byte is waiting at that point. Transmit-buffer-empty is 1 again as soon as the waiting byte has moved into the shifter.
- R6: When `tx_en` rises, transmit-buffer-empty and shift-complete both read 1 in that cycle and `tx_irq` pulses. After that, `tx_irq` pulses for one cycle on each rise of shift-complete (`tint_tsc`=1) or of transmit-buffer-empty (`tint_tsc`=0).
- R7: A parity mismatch sets bit 4 and bit 6 in the same cycle that receive-buffer-full rises.
- R8: A 0 sampled in the first stop bit sets the framing flag (bit 5), and the data is still delivered.
- R9: When a frame completes while the receive buffer is full, the overrun flag (bit 3) is set and the buffered byte is kept.
- R10: A pulse on `sts_clr` clears bits 3 to 6 and leaves receive-buffer-full unchanged.
- R11: While `sio_en` is 0, status bits 0 to 6 read 0 and both buffers are emptied.
- R12: A low level on `rxd` starts a frame only if it is still low at the 8th tick. A shorter glitch delivers nothing.
- R13: `rx_valid` holds and `rx_data` stays stable until `rx_ready`. `rx_irq` pulses once when the buffer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sio_en | input | 1 | Serial function enable; 0 clears all flags |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | 1 selects two stop bits |
| tint_tsc | input | 1 | Transmit interrupt source: 1 shift-complete, 0 buffer-empty |
| ext_sel | input | 1 | 1 takes ticks from `ext_clk` |
| baud_div | input | DIV_W | Internal divider value n (ratio n+1) |
| ext_clk | input | 1 | External oversampling clock |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit holding buffer empty |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding buffer full |
| rx_ready | input | 1 | Consumer takes the received byte |
| sts_clr | input | 1 | Clear the error flags |
| status | output | 8 | Status byte (layout in R1) |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The main stimulus is a loopback sweep over all sixteen format combinations. Each format carries eight data patterns: all zeros, all ones, the two alternating bytes, the lowest and highest single bits, 7F, and one value per format. Together these patterns separate bit order, parity sense, character length and stop-bit count, and in every sweep the bit seen at the middle of each bit time on `txd` is checked.

Frames with a wrong parity bit or a low stop bit are built by hand so that each error flag is triggered by itself. A short glitch on `rxd` checks start confirmation. Two unread frames in a row check overrun. Measuring the start-bit length under a divider value and under an external clock separates the two tick sources.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic char7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } sio_fmt_t;

  // total bit times of one frame, start through last stop
  function automatic logic [3:0] frame_len(sio_fmt_t f);
    return 4'd10 - {3'b0, f.char7} + {3'b0, f.par_en} + {3'b0, f.stop2};
  endfunction

  // LSB-first serial image, unused tail bits stay at the idle level
  function automatic logic [FRAME_MAX-1:0] frame_image(logic [7:0] d, sio_fmt_t f);
    logic [FRAME_MAX-1:0] v;
    logic [7:0] m;
    v = '1;
    v[0] = 1'b0;
    m = f.char7 ? {1'b0, d[6:0]} : d;
    for (int i = 0; i < 8; i++)
      if (i < 7 || !f.char7) v[i+1] = m[i];
    if (f.par_en) v[f.char7 ? 8 : 9] = (^m) ^ f.par_odd;
    return v;
  endfunction
endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       es;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      es  <= '0;
    end else begin
      es  <= {es[1:0], ext_clk};
      cnt <= (cnt == '0) ? div : cnt - 1'b1;
    end

  assign tick = ext_sel ? (es[1] & ~es[2]) : (cnt == '0);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  sio_fmt_t   fmt,
  input  logic       push,
  input  logic [7:0] pdata,
  output logic       txd,
  output logic       tbe,
  output logic       tsc
);
  logic [FRAME_MAX-1:0] sh;
  logic [7:0]           hold;
  logic [3:0]           sub, idx, nb;
  logic                 busy, end_bit, start_now;

  assign nb        = frame_len(fmt);
  assign end_bit   = busy && sub == 4'd15 && idx == nb - 4'd1;
  assign start_now = tick && !tbe && (!busy || end_bit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '1; hold <= '0; sub <= '0; idx <= '0;
      busy <= 1'b0; tbe <= 1'b1; tsc <= 1'b1;
    end else if (!run) begin
      sh <= '1; sub <= '0; idx <= '0;
      busy <= 1'b0; tbe <= 1'b1; tsc <= 1'b1;
    end else begin
      if (start_now) begin
        sh   <= frame_image(hold, fmt);
        busy <= 1'b1;
        sub  <= '0;
        idx  <= '0;
        tbe  <= 1'b1;
        tsc  <= 1'b0;
      end else if (tick && busy) begin
        sub <= sub + 1'b1;
        if (sub == 4'd15) begin
          if (idx == nb - 4'd1) busy <= 1'b0;
          else begin
            idx <= idx + 1'b1;
            sh  <= {1'b1, sh[FRAME_MAX-1:1]};
            if (idx == nb - 4'd2 && tbe) tsc <= 1'b1;
          end
        end
      end
      if (push) begin
        hold <= pdata;
        tbe  <= 1'b0;
      end
    end

  assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       flags_on,
  input  logic       tick,
  input  sio_fmt_t   fmt,
  input  logic       rxd,
  input  logic       pop,
  input  logic       err_clr,
  output logic [7:0] data,
  output logic       rbf,
  output logic       oe,
  output logic       pe,
  output logic       fe
);
  logic [7:0] sh;
  logic [3:0] sub, idx, nd, stop_idx;
  logic       s1, s2, prev, busy, par, at_sample, done, perr;

  assign nd        = fmt.char7 ? 4'd7 : 4'd8;
  assign stop_idx  = nd + {3'b0, fmt.par_en} + 4'd1;
  assign at_sample = busy && tick && (idx == '0 ? sub == 4'd7 : sub == 4'd15);
  assign done      = at_sample && idx == stop_idx;
  assign perr      = fmt.par_en && (par != fmt.par_odd);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1; busy <= 1'b0;
      sub <= '0; idx <= '0; sh <= '0; par <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (!run) begin
        busy <= 1'b0;
        prev <= 1'b1;
      end else if (tick) begin
        prev <= s2;
        if (!busy) begin
          if (prev && !s2) begin
            busy <= 1'b1; sub <= '0; idx <= '0; sh <= '0; par <= 1'b0;
          end
        end else if (at_sample) begin
          sub <= '0;
          if ((idx == '0 && s2) || done) busy <= 1'b0;
          else begin
            idx <= idx + 1'b1;
            if (idx != '0) begin
              if (idx <= nd) sh[3'(idx - 4'd1)] <= s2;
              par <= par ^ s2;
            end
          end
        end else sub <= sub + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data <= '0; rbf <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0;
    end else if (!flags_on) begin
      rbf <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0;
    end else begin
      if (pop) rbf <= 1'b0;
      if (done) begin
        if (!rbf || pop) data <= sh;
        else oe <= 1'b1;
        rbf <= 1'b1;
        if (perr) pe <= 1'b1;
        if (!s2) fe <= 1'b1;
      end
      if (err_clr) begin
        oe <= 1'b0; pe <= 1'b0; fe <= 1'b0;
      end
    end
endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sio_en,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             char7,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop2,
  input  logic             tint_tsc,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ext_clk,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic             sts_clr,
  output logic [7:0]       status,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             txd,
  input  logic             rxd
);
  sio_fmt_t fmt;
  logic tick, tx_run, tbe_raw, tsc_raw, tbe_s, tsc_s;
  logic rbf, oe, pe, fe, tsel, tsel_q, rbf_q;

  assign fmt    = '{char7: char7, par_en: par_en, par_odd: par_odd, stop2: stop2};
  assign tx_run = sio_en & tx_en;

  sio_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .div(baud_div), .tick(tick));

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .run(tx_run), .tick(tick), .fmt(fmt),
    .push(tx_valid & tx_ready), .pdata(tx_data),
    .txd(txd), .tbe(tbe_raw), .tsc(tsc_raw));

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .run(sio_en & rx_en), .flags_on(sio_en),
    .tick(tick), .fmt(fmt), .rxd(rxd), .pop(rx_ready & rbf),
    .err_clr(sts_clr), .data(rx_data), .rbf(rbf), .oe(oe), .pe(pe), .fe(fe));

  assign tbe_s    = tx_run & tbe_raw;
  assign tsc_s    = tx_run & tsc_raw;
  assign tx_ready = tbe_s;
  assign rx_valid = rbf;
  assign status   = {1'b1, oe | pe | fe, fe, pe, oe, tsc_s, rbf, tbe_s};
  assign tsel     = tint_tsc ? tsc_s : tbe_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tsel_q <= 1'b0;
      rbf_q  <= 1'b0;
    end else begin
      tsel_q <= tsel;
      rbf_q  <= rbf;
    end

  assign tx_irq = tsel & ~tsel_q;
  assign rx_irq = rbf & ~rbf_q;
endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sio_en,
  input logic       tx_en,
  input logic       char7,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       sts_clr,
  input logic [7:0] status,
  input logic       tx_irq,
  input logic       txd
);
  AST_TE_RISE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) && sio_en |-> status[0] && status[2] && tx_irq); // R6
  AST_TXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R6
  AST_TXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && $past(!tx_en) |-> txd); // R2
  AST_TX_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R5
  AST_ERR_WITH_RBF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> status[1]); // R7
  AST_CLR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr |=> status[6:3] == 4'b0); // R10
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sio_en |=> status[6:3] == 4'b0 && !status[1]); // R11
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && sio_en |=> rx_valid && $stable(rx_data)); // R13
  AST_MSB7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && char7 |-> !rx_data[7]); // R4
endmodule

bind sio_uart sio_uart_chk u_sio_uart_chk (
  .clk(clk), .rst_n(rst_n), .sio_en(sio_en), .tx_en(tx_en), .char7(char7),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .sts_clr(sts_clr),
  .status(status), .tx_irq(tx_irq), .txd(txd));

// File: tb/test_sio_uart.sv
module test_sio_uart;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sio_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic char7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, tint_tsc = 1'b0;
  logic ext_sel = 1'b0, ext_clk = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, sts_clr = 1'b0;
  logic tx_ready, rx_valid, tx_irq, rx_irq, txd, rxd;
  logic [7:0] rx_data, status;
  logic loop = 1'b1, drv = 1'b1;
  int nvec = 0, nerr = 0, txirq_cnt = 0, rxirq_cnt = 0;

  assign rxd = loop ? txd : drv;

  always #10 clk = ~clk;
  always #40 ext_clk = ~ext_clk;

  sio_uart i_sio_uart (
    .clk(clk), .rst_n(rst_n), .sio_en(sio_en), .tx_en(tx_en), .rx_en(rx_en),
    .char7(char7), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .tint_tsc(tint_tsc), .ext_sel(ext_sel), .baud_div(baud_div), .ext_clk(ext_clk),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sts_clr(sts_clr), .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .txd(txd), .rxd(rxd));

  always @(negedge clk) begin
    if (tx_irq) txirq_cnt++;
    if (rx_irq) rxirq_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ndata();
    return char7 ? 7 : 8;
  endfunction

  function automatic int nbits();
    return 2 + ndata() + int'(par_en) + int'(stop2);
  endfunction

  // expected serial bit k of a character, from the frame rules
  function automatic logic fbit(input logic [7:0] d, input int k);
    int nd = ndata();
    int ones = $countones(char7 ? (d & 8'h7f) : d);
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (par_en && k == nd + 1) return logic'((ones + int'(par_odd)) % 2);
    return 1'b1;
  endfunction

  task automatic pop_rx();
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d, input logic [7:0] exp_rx,
                         input logic exp_oe, input logic do_pop);
    int nb = nbits();
    int ic0;
    while (!tx_ready) cyc(1);
    ic0 = txirq_cnt;
    tx_data = d; tx_valid = 1'b1; cyc(1); tx_valid = 1'b0;
    while (txd) cyc(1);
    cyc(7);
    for (int k = 0; k < nb; k++) begin
      chk("R2 txd bit", txd, fbit(d, k));
      chk("R5 shift-complete", status[2], k == nb - 1);
      if (k == 1) chk("R6 tx_irq source", txirq_cnt, tint_tsc ? ic0 : ic0 + 1);
      cyc(16);
    end
    chk("R6 tx_irq count", txirq_cnt, ic0 + 1);
    chk("R4 rx_valid", rx_valid, 1);
    chk("R4 rx_data", rx_data, exp_rx);
    chk("R9 overrun flag", status[3], exp_oe);
    chk("R7 parity flag clean", status[5:4], 0);
    if (do_pop) begin
      pop_rx();
      chk("R13 pop empties", rx_valid, 0);
    end
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic bad_par, input logic low_stop);
    int nb = nbits();
    for (int k = 0; k < nb; k++) begin
      logic b = fbit(d, k);
      if (bad_par && par_en && k == ndata() + 1) b = ~b;
      if (low_stop && k == ndata() + 1 + int'(par_en)) b = 1'b0;
      drv = b;
      cyc(16);
    end
    drv = 1'b1;
    cyc(20);
  endtask

  task automatic start_len(input int exp, input string req);
    int n = 0;
    while (!tx_ready) cyc(1);
    tx_data = 8'h01; tx_valid = 1'b1; cyc(1); tx_valid = 1'b0;
    while (txd) cyc(1);
    while (!txd) begin n++; cyc(1); end
    chk(req, n, exp);
    while (!status[2]) cyc(1);
    cyc(100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] pats [8];
    sio_en = 1'b1;
    cyc(5); rst_n = 1'b1; cyc(1);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset tx_ready", tx_ready, 0);
    chk("R13 reset rx_valid", rx_valid, 0);

    tx_en = 1'b1; #1;
    chk("R6 TE rise status", {status[2], status[0]}, 2'b11);
    chk("R6 TE rise tx_irq", tx_irq, 1);
    cyc(1);
    chk("R6 tx_irq one cycle", tx_irq, 0);
    rx_en = 1'b1;

    // loopback sweep: all formats, eight patterns each
    for (int f = 0; f < 16; f++) begin
      {char7, par_en, par_odd, stop2} = 4'(f);
      tint_tsc = f[0] ^ f[2];
      pats = '{8'h00, 8'hff, 8'h55, 8'haa, 8'h01, 8'h80, 8'h7f, 8'(f * 17 + 3)};
      for (int p = 0; p < 8; p++)
        send_tx(pats[p], char7 ? (pats[p] & 8'h7f) : pats[p], 1'b0, 1'b1);
    end

    // overrun, then status clear
    {char7, par_en, par_odd, stop2} = 4'b0000;
    tint_tsc = 1'b0;
    send_tx(8'h3c, 8'h3c, 1'b0, 1'b0);
    send_tx(8'hc3, 8'h3c, 1'b1, 1'b0);
    chk("R9 summary flag", status[6], 1);
    sts_clr = 1'b1; cyc(1); sts_clr = 1'b0;
    chk("R10 errors cleared", status[6:3], 0);
    chk("R10 buffer kept full", status[1], 1);
    pop_rx();

    // parity error on a hand-built frame
    loop = 1'b0;
    par_en = 1'b1;
    rxirq_cnt = 0;
    drive_rx(8'h03, 1'b1, 1'b0);
    chk("R7 data", rx_data, 8'h03);
    chk("R7 parity + summary", {status[6], status[5], status[4], status[1]}, 4'b1011);
    chk("R13 rx_irq once", rxirq_cnt, 1);
    cyc(10);
    chk("R13 rx_valid held", rx_valid, 1);

    // disable clears everything
    sio_en = 1'b0; cyc(1);
    chk("R11 status disabled", status, 8'h80);
    chk("R11 rx_valid disabled", rx_valid, 0);
    sio_en = 1'b1; cyc(2);

    // framing error
    par_en = 1'b0;
    drive_rx(8'h5a, 1'b0, 1'b1);
    chk("R8 data", rx_data, 8'h5a);
    chk("R8 framing + summary", {status[6], status[5], status[4], status[3]}, 4'b1100);
    sts_clr = 1'b1; cyc(1); sts_clr = 1'b0;
    pop_rx();

    // short glitch
    drv = 1'b0; cyc(5); drv = 1'b1; cyc(40);
    chk("R12 glitch ignored", rx_valid, 0);
    drive_rx(8'h96, 1'b0, 1'b0);
    chk("R12 frame after glitch", {rx_valid, rx_data}, {1'b1, 8'h96});
    pop_rx();

    // tick sources
    baud_div = 8'd2;
    start_len(48, "R3 divider n=2");
    baud_div = 8'd0; ext_sel = 1'b1;
    start_len(64, "R3 external clock");

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule